// File: doc/BRIEF.md
# Periodic Threshold Monitor with Hysteresis

This block paces an external 8-bit converter. A down-counter loaded from a programmable interval starts one conversion each time it expires. The converter is reached through a start/done handshake and converts one of four selectable sources. Each returned value is kept as the latest result and compared against a high and a low threshold. The block remembers whether the signal was above the high level or below the low level. It raises a sticky flag only when the signal enters one of those states, so the host sees one event per crossing and not one per conversion.

A host programs the block through a small word-wide register port. The control byte selects the source, enables the two interrupts and the automatic wake request, and holds the three power enables. The threshold word, the interval and the status are at their own addresses. Reading the status returns the result and the two flags, then clears the flags. When the automatic wake option is on and the designated discriminator source (source 3) is selected, a wake request follows the above-high state. This lets a receive path be brought up without host help.

Top module: `aux_level_monitor`

## Requirements
- R1: After reset the control byte is 0 (everything powered down), both thresholds are 0, the interval reads DEF_IVL (2080 cycles, 20.8 µs at 100 MHz), the status reads 0, and conv_start, irq and wake_req are low.
- R2: While powered, conv_start is a one-cycle pulse issued every INTERVAL clock cycles (a value of 0 acts as 1). At most one conversion is outstanding. Writing the interval register (address 2) restarts the count.
- R3: Conversions start only when control bits 7 (clock), 6 (bias) and 5 (converter) are all set. While any of them is clear, a status read (address 3) returns 0.
- R4: conv_src always equals control bits [1:0].
- R5: Status bits [7:0] hold the value returned by the most recent accepted conversion.
- R6: Status bit 9 (high flag) is set by a conversion whose result is strictly greater than the high threshold when the previous result was not. A result at or below the high threshold re-arms it.
- R7: Status bit 8 (low flag) is set by a conversion whose result is strictly less than the low threshold when the previous result was not. A result at or above the low threshold re-arms it.
- R8: Both flags stay set until a status read clears them. A new crossing in the same cycle as the read takes priority over the clear.
- R9: irq is high one cycle after any flag whose enable is set: control bit 2 enables the high flag and bit 3 the low flag. A flag with its enable clear still shows in the status but does not raise irq.
- R10: wake_req is high when control bit 4 (auto wake) is set, control bits [1:0] equal 3, and the last result was above the high threshold. It is low otherwise.
- R11: The threshold word at address 1 holds the high threshold in bits [15:8] and the low threshold in bits [7:0]. If low is not below high, both comparisons are still made exactly as written and no error is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; rdata is valid on the next cycle |
| addr | input | 2 | Register address: 0 control, 1 thresholds, 2 interval, 3 status |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| conv_start | output | 1 | One-cycle request to start a conversion |
| conv_src | output | 2 | Source to convert |
| conv_done | input | 1 | Conversion complete, qualifies conv_data |
| conv_data | input | 8 | Conversion value |
| irq | output | 1 | Active-high interrupt |
| wake_req | output | 1 | Receive-path wake request |

## Verification
The bench uses the default 8-bit data width and 16-bit interval, and keeps the 2080-cycle reset interval only long enough to read it back. It then writes an interval of 40 cycles, so each table entry costs a few dozen cycles and the spacing between starts can be measured exactly. A scripted converter model answers two cycles after each start. This puts every crossing, re-arm at exact equality, sticky clear, power-down gate and inverted-threshold case within a short run.

// File: rtl/aux_mon_pkg.sv
package aux_mon_pkg;
  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_THR   = 2'd1;
  localparam logic [1:0] ADDR_IVL   = 2'd2;
  localparam logic [1:0] ADDR_STAT  = 2'd3;
  localparam logic [1:0] WAKE_SRC   = 2'd3;

  typedef struct packed {
    logic       clk_pwr;
    logic       bias_pwr;
    logic       adc_pwr;
    logic       auto_wake;
    logic       lo_irq_en;
    logic       hi_irq_en;
    logic [1:0] src;
  } ctrl_t;
endpackage

// File: rtl/aux_mon_pacer.sv
module aux_mon_pacer #(
  parameter int IVL_W   = 16,
  parameter int DEF_IVL = 2080
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [IVL_W-1:0] ivl,
  output logic             tick
);
  localparam logic [IVL_W-1:0] START_CNT = IVL_W'(DEF_IVL - 1);

  logic [IVL_W-1:0] cnt;
  logic [IVL_W-1:0] reload;

  assign reload = (ivl == '0) ? IVL_W'(1) : ivl;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= START_CNT;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (load) begin
        cnt <= reload - 1'b1;
      end else if (cnt == '0) begin
        cnt  <= reload - 1'b1;
        tick <= 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/aux_mon_conv_seq.sv
module aux_mon_conv_seq (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic tick,
  input  logic conv_done,
  output logic conv_start,
  output logic accept
);
  logic busy;

  assign accept = busy & conv_done & enable;

  always_ff @(posedge clk) begin
    if (rst) begin
      conv_start <= 1'b0;
      busy       <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      if (!enable) begin
        busy <= 1'b0;
      end else if (busy) begin
        if (conv_done) busy <= 1'b0;
      end else if (tick) begin
        conv_start <= 1'b1;
        busy       <= 1'b1;
      end
    end
  end

  p_single_start_r2: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);
  p_start_powered_r3: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> $past(enable));
endmodule

// File: rtl/aux_mon_crossing.sv
module aux_mon_crossing #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic [DW-1:0] data,
  input  logic [DW-1:0] hi_th,
  input  logic [DW-1:0] lo_th,
  input  logic          clr,
  output logic [DW-1:0] result,
  output logic          above_q,
  output logic          hi_flag,
  output logic          lo_flag
);
  logic below_q;
  logic above_now, below_now;

  assign above_now = data > hi_th;
  assign below_now = data < lo_th;

  always_ff @(posedge clk) begin
    if (rst) begin
      result  <= '0;
      above_q <= 1'b0;
      below_q <= 1'b0;
      hi_flag <= 1'b0;
      lo_flag <= 1'b0;
    end else begin
      if (accept) begin
        result  <= data;
        above_q <= above_now;
        below_q <= below_now;
      end
      hi_flag <= (accept & above_now & ~above_q) | (hi_flag & ~clr);
      lo_flag <= (accept & below_now & ~below_q) | (lo_flag & ~clr);
    end
  end

  p_hi_on_conv_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(hi_flag) |-> $past(accept));
  p_lo_on_conv_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(lo_flag) |-> $past(accept));
  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    $past(clr && !accept) |-> (!hi_flag && !lo_flag));
endmodule

// File: rtl/aux_level_monitor.sv
module aux_level_monitor #(
  parameter int DW      = 8,
  parameter int IVL_W   = 16,
  parameter int DEF_IVL = 2080
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [1:0]    addr,
  input  logic [2*DW-1:0] wdata,
  output logic [2*DW-1:0] rdata,
  output logic          conv_start,
  output logic [1:0]    conv_src,
  input  logic          conv_done,
  input  logic [DW-1:0] conv_data,
  output logic          irq,
  output logic          wake_req
);
  import aux_mon_pkg::*;

  localparam int BUS_W = 2 * DW;

  ctrl_t            ctrl_q;
  logic [DW-1:0]    hi_q, lo_q;
  logic [IVL_W-1:0] ivl_q;
  logic             powered;
  logic             wr_ivl, rd_stat;
  logic [IVL_W-1:0] pacer_ivl;
  logic             tick, accept;
  logic [DW-1:0]    result;
  logic             above_q, hi_flag, lo_flag;

  assign powered   = ctrl_q.clk_pwr & ctrl_q.bias_pwr & ctrl_q.adc_pwr;
  assign wr_ivl    = wr_en && (addr == ADDR_IVL);
  assign rd_stat   = rd_en && (addr == ADDR_STAT);
  assign pacer_ivl = wr_ivl ? wdata[IVL_W-1:0] : ivl_q;
  assign conv_src  = ctrl_q.src;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      ivl_q  <= IVL_W'(DEF_IVL);
    end else if (wr_en) begin
      case (addr)
        ADDR_CTRL: ctrl_q <= ctrl_t'(wdata[7:0]);
        ADDR_THR:  begin
          hi_q <= wdata[BUS_W-1:DW];
          lo_q <= wdata[DW-1:0];
        end
        ADDR_IVL:  ivl_q <= wdata[IVL_W-1:0];
        default:   ;
      endcase
    end
  end

  aux_mon_pacer #(.IVL_W(IVL_W), .DEF_IVL(DEF_IVL)) pacer_i (
    .clk(clk), .rst(rst), .load(wr_ivl), .ivl(pacer_ivl), .tick(tick)
  );

  aux_mon_conv_seq seq_i (
    .clk(clk), .rst(rst), .enable(powered), .tick(tick),
    .conv_done(conv_done), .conv_start(conv_start), .accept(accept)
  );

  aux_mon_crossing #(.DW(DW)) cross_i (
    .clk(clk), .rst(rst), .accept(accept), .data(conv_data),
    .hi_th(hi_q), .lo_th(lo_q), .clr(rd_stat), .result(result),
    .above_q(above_q), .hi_flag(hi_flag), .lo_flag(lo_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      irq      <= 1'b0;
      wake_req <= 1'b0;
    end else begin
      irq      <= (hi_flag & ctrl_q.hi_irq_en) | (lo_flag & ctrl_q.lo_irq_en);
      wake_req <= ctrl_q.auto_wake & (ctrl_q.src == WAKE_SRC) & above_q;
      if (rd_en) begin
        case (addr)
          ADDR_CTRL: rdata <= BUS_W'(ctrl_q);
          ADDR_THR:  rdata <= {hi_q, lo_q};
          ADDR_IVL:  rdata <= BUS_W'(ivl_q);
          default:   rdata <= powered ? BUS_W'({hi_flag, lo_flag, result}) : '0;
        endcase
      end
    end
  end

  p_wake_cfg_r10: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> $past(ctrl_q.auto_wake && ctrl_q.src == WAKE_SRC));
  p_irq_src_r9: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(hi_flag || lo_flag));
endmodule

// File: tb/aux_level_monitor_tb_top.sv
module aux_level_monitor_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        conv_start;
  logic [1:0]  conv_src;
  logic        conv_done = 1'b0;
  logic [7:0]  conv_data = '0;
  logic        irq, wake_req;

  int checks = 0, errors = 0;
  int cyc = 0, conv_count = 0, starts = 0;
  int last_start = 0, prev_start = 0;
  logic [7:0] next_val = '0;

  // {wake, hi_flag, lo_flag, value} with high 0x80, low 0x40
  localparam logic [10:0] VEC [10] = '{
    {3'b000, 8'h60}, {3'b110, 8'h90}, {3'b100, 8'hA0}, {3'b000, 8'h80},
    {3'b110, 8'h81}, {3'b001, 8'h30}, {3'b000, 8'h20}, {3'b000, 8'h40},
    {3'b001, 8'h3F}, {3'b110, 8'hFF}
  };

  aux_level_monitor dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .conv_start(conv_start), .conv_src(conv_src),
    .conv_done(conv_done), .conv_data(conv_data), .irq(irq), .wake_req(wake_req)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic convert(input logic [7:0] v);
    int c0;
    next_val = v;
    c0 = conv_count;
    for (int i = 0; i < 400 && conv_count < c0 + 2; i++) @(negedge clk);
    if (conv_count < c0 + 2) chk("R2 conversion timeout", 0, 1);
    @(negedge clk);
  endtask

  // converter model: answers two cycles after each start
  initial begin
    forever begin
      @(negedge clk);
      if (conv_start) begin
        starts++;
        prev_start = last_start;
        last_start = cyc;
        repeat (2) @(negedge clk);
        conv_done = 1'b1;
        conv_data = next_val;
        @(negedge clk);
        conv_done = 1'b0;
        conv_count++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int c0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 wake", wake_req, 0);
    chk("R1 start", conv_start, 0);
    rd(2'd2, d); chk("R1 interval default", d, 2080);
    rd(2'd0, d); chk("R1 ctrl", d, 0);
    rd(2'd3, d); chk("R1 status", d, 0);

    wr(2'd1, 16'h8040);
    wr(2'd2, 16'd40);
    wr(2'd0, 16'h00FF);
    rd(2'd1, d); chk("R11 threshold word", d, 16'h8040);
    chk("R4 src 3", conv_src, 2'd3);

    for (int i = 0; i < 10; i++) begin
      convert(VEC[i][7:0]);
      chk("R9 irq", irq, VEC[i][9] | VEC[i][8]);
      chk("R10 wake", wake_req, VEC[i][10]);
      rd(2'd3, d);
      chk("R5/R6/R7 status", d, {6'd0, VEC[i][9:0]});
      @(negedge clk);
      chk("R8 cleared irq", irq, 0);
      rd(2'd3, d);
      chk("R8 flags cleared", d[9:8], 0);
    end
    chk("R2 start spacing", last_start - prev_start, 40);

    // R9 enables off: flag in status, no irq
    wr(2'd0, 16'h00E3);
    convert(8'h30);
    chk("R9 irq masked", irq, 0);
    rd(2'd3, d); chk("R9 low flag still visible", d, 16'h0130);

    // R10 auto wake with another source
    wr(2'd0, 16'h00F1);
    chk("R4 src 1", conv_src, 2'd1);
    convert(8'h90);
    chk("R10 wake needs source 3", wake_req, 0);
    rd(2'd3, d); chk("R6 high flag", d, 16'h0290);

    // R11 inverted thresholds: high 0x10, low 0x20
    wr(2'd1, 16'h1020);
    wr(2'd0, 16'h00FF);
    convert(8'h18);
    chk("R11 wake", wake_req, 1);
    chk("R11 irq", irq, 1);
    rd(2'd3, d); chk("R11 status", d, 16'h0118);

    // R3 power gating
    wr(2'd0, 16'h007F);
    repeat (10) @(negedge clk);
    c0 = starts;
    repeat (200) @(negedge clk);
    chk("R3 no starts unpowered", starts, c0);
    rd(2'd3, d); chk("R3 status reads 0", d, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule